// File: doc/BRIEF.md
# Redundant Thread Load Value Queue

This block passes load results from one copy of a redundantly executed program to a second copy. The leading copy is the only one that reads memory. For each load it performs, it writes the address and the returned word into a first-in first-out store. The trailing copy never reads memory. It asks the queue for its next load in program order, gives the address it computed, and gets back the word the leading copy saw. The two copies therefore see identical input data, even when a device register or another processor changes memory between their loads. The queue also compares the trailing address with the recorded one. A difference sets a fault flag that stays set.

The copies do not run in lock step. The leading copy can run ahead by up to `DEPTH` loads before its push port stalls. When the queue is empty, a trailing request waits. A small state machine on the trailing side has three states. `T_IDLE` waits for a request. Transition idle-to-ack: a request meets a non-empty queue. Transition idle-to-wait: a request meets an empty queue. `T_WAIT` holds a pending request. Transition wait-to-ack: an entry is present. `T_ACK` is the single cycle in which data is returned. Transition ack-to-idle: always.

Top module: `redund_load_fifo`

## Requirements
- R1: After reset, `fill_count` is 0, `lead_ready` is 1, `trail_ack` is 0 and `fault` is 0.
- R2: `lead_ready` is low exactly while `fill_count` equals `DEPTH`. A push offered while `lead_ready` is low is not stored and leaves `fill_count` unchanged.
- R3: Words are returned on `trail_data` in the order the leading side pushed them.
- R4: A trailing request made while the queue is empty gives no `trail_ack` until an entry has been pushed. It then completes with that entry's word.
- R5: An entry is removed on the clock edge at which the state machine leaves `T_IDLE` or `T_WAIT` with a non-empty queue. `trail_ack` is high for exactly the one following cycle, with the word on `trail_data`. A request held through `T_ACK` does not remove a second entry.
- R6: When `trail_addr` differs from the recorded address of the entry being removed, `fault` is 1 in the `trail_ack` cycle. The entry is still removed and its word is still returned.
- R7: `fault` stays 1 until reset.
- R8: `fill_count` changes each cycle by +1 for an accepted push (`lead_valid` and `lead_ready` both high on the previous edge) and by −1 for each `trail_ack`. A push and a removal on the same edge leave it unchanged.
- R9: `DEPTH` pushes with no removals are all accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_valid | input | 1 | Leading copy offers a load record |
| lead_ready | output | 1 | Queue can accept a record |
| lead_addr | input | AW | Address used by the leading load |
| lead_data | input | DW | Word returned by memory to the leading load |
| trail_req | input | 1 | Trailing copy requests its next load value; held until `trail_ack` |
| trail_addr | input | AW | Address computed by the trailing copy |
| trail_ack | output | 1 | One-cycle return strobe |
| trail_data | output | DW | Recorded word for the trailing load |
| fault | output | 1 | Sticky address mismatch flag |
| fill_count | output | $clog2(DEPTH+1) | Number of stored entries |

## Verification
A push and a removal can fall on the same clock edge, and the counter must then net both. The bench provokes this by running the push driver and the trailing requester in parallel, first from a full queue and then from an empty one. In those runs the removal frees space while a stalled push waits to be accepted, and a push lands while a trailing request is pending. Each returned word is compared against a scoreboard of pushed records. `fill_count` must return to zero with every word delivered in order.

// File: rtl/rlf_pkg.sv
`timescale 1ns/1ps
package rlf_pkg;
    typedef enum logic [1:0] {
        T_IDLE = 2'd0,
        T_WAIT = 2'd1,
        T_ACK  = 2'd2
    } trail_state_e;
endpackage

// File: rtl/rlf_ptrs.sv
`timescale 1ns/1ps
module rlf_ptrs #(
    parameter int DEPTH = 16,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);

    logic [PW-1:0] wr_nx, rd_nx;

    generate
        if ((1 << PW) == DEPTH) begin : g_pow2
            assign wr_nx = wr_ptr + 1'b1;
            assign rd_nx = rd_ptr + 1'b1;
        end else begin : g_wrap
            assign wr_nx = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            assign rd_nx = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_nx;
            if (pop)  rd_ptr <= rd_nx;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign full  = (count == FULLV);
    assign empty = (count == '0);
endmodule

// File: rtl/rlf_mem.sv
`timescale 1ns/1ps
module rlf_mem #(
    parameter int DEPTH = 16,
    parameter int W     = 64,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [PW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/rlf_trail_fsm.sv
`timescale 1ns/1ps
module rlf_trail_fsm
    import rlf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic empty,
    output logic take,
    output logic ack
);
    trail_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= T_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            T_IDLE: begin
                if (req && !empty)     state_nx = T_ACK;
                else if (req && empty) state_nx = T_WAIT;
            end
            T_WAIT: begin
                if (!empty) state_nx = T_ACK;
            end
            T_ACK:   state_nx = T_IDLE;
            default: state_nx = T_IDLE;
        endcase
    end

    always_comb begin
        take = 1'b0;
        ack  = 1'b0;
        unique case (state)
            T_IDLE:  take = req && !empty;
            T_WAIT:  take = !empty;
            T_ACK:   ack  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/redund_load_fifo.sv
`timescale 1ns/1ps
module redund_load_fifo #(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lead_valid,
    output logic          lead_ready,
    input  logic [AW-1:0] lead_addr,
    input  logic [DW-1:0] lead_data,
    input  logic          trail_req,
    input  logic [AW-1:0] trail_addr,
    output logic          trail_ack,
    output logic [DW-1:0] trail_data,
    output logic          fault,
    output logic [CW-1:0] fill_count
);
    logic          push, take, full, empty;
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [AW+DW-1:0] head;
    logic [DW-1:0] data_q;
    logic          fault_q;

    assign push = lead_valid && !full;

    rlf_ptrs #(.DEPTH(DEPTH)) ptrs_i (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(take),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(fill_count),
        .full(full), .empty(empty)
    );

    rlf_mem #(.DEPTH(DEPTH), .W(AW + DW)) mem_i (
        .clk(clk), .we(push), .waddr(wr_ptr), .wdata({lead_addr, lead_data}),
        .raddr(rd_ptr), .rdata(head)
    );

    rlf_trail_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .req(trail_req), .empty(empty),
        .take(take), .ack(trail_ack)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            fault_q <= 1'b0;
        end else if (take) begin
            data_q <= head[DW-1:0];
            if (head[AW+DW-1:DW] != trail_addr) fault_q <= 1'b1;
        end
    end

    assign lead_ready = !full;
    assign trail_data = data_q;
    assign fault      = fault_q;
endmodule

// File: rtl/rlf_chk.sv
`timescale 1ns/1ps
module rlf_chk #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lead_valid,
    input logic          lead_ready,
    input logic          trail_ack,
    input logic          fault,
    input logic [CW-1:0] fill_count
);
    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fill_count) <= DEPTH);

    // R2
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fill_count) == DEPTH) |-> !lead_ready);

    // R8
    count_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> int'(fill_count) == int'($past(fill_count))
                  + int'($past(lead_valid && lead_ready)) - int'(trail_ack));

    // R4
    ack_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && trail_ack) |-> ($past(fill_count) != '0));

    // R5
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trail_ack |=> !trail_ack);

    // R6
    fault_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $rose(fault)) |-> trail_ack);

    // R7
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);
endmodule

bind redund_load_fifo rlf_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .lead_valid(lead_valid), .lead_ready(lead_ready),
    .trail_ack(trail_ack), .fault(fault), .fill_count(fill_count)
);

// File: tb/redund_load_fifo_tb_top.sv
`timescale 1ns/1ps
module redund_load_fifo_tb_top;
    localparam int DEPTH = 16;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lead_valid = 1'b0;
    logic lead_ready;
    logic [AW-1:0] lead_addr = '0;
    logic [DW-1:0] lead_data = '0;
    logic trail_req = 1'b0;
    logic [AW-1:0] trail_addr = '0;
    logic trail_ack;
    logic [DW-1:0] trail_data;
    logic fault;
    logic [CW-1:0] fill_count;

    int checks = 0;
    int fails = 0;
    logic [AW+DW-1:0] exp_q[$];

    always #5 clk = ~clk;

    redund_load_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .lead_valid(lead_valid), .lead_ready(lead_ready),
        .lead_addr(lead_addr), .lead_data(lead_data), .trail_req(trail_req),
        .trail_addr(trail_addr), .trail_ack(trail_ack), .trail_data(trail_data),
        .fault(fault), .fill_count(fill_count)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: records each item in the scoreboard as it is offered
    task automatic push_item(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        lead_valid = 1'b1; lead_addr = a; lead_data = d;
        exp_q.push_back({a, d});
        while (!lead_ready) @(negedge clk);
        @(negedge clk);
        lead_valid = 1'b0;
    endtask

    // monitor side: trailing request, compares the returned word with the scoreboard
    task automatic pop_item(input bit bad, input string tag);
        logic [AW+DW-1:0] e;
        while (exp_q.size() == 0) @(negedge clk);
        @(negedge clk);
        e = exp_q[0];
        trail_req = 1'b1;
        trail_addr = bad ? ~e[AW+DW-1:DW] : e[AW+DW-1:DW];
        do @(negedge clk); while (!trail_ack);
        chk(trail_data == e[DW-1:0], tag, 64'(trail_data), 64'(e[DW-1:0]));
        e = exp_q.pop_front();
        trail_req = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk(fill_count == 0, "R1 count", 64'(fill_count), 0);
        chk(lead_ready == 1'b1, "R1 ready", 64'(lead_ready), 1);
        chk(trail_ack == 1'b0, "R1 ack", 64'(trail_ack), 0);
        chk(fault == 1'b0, "R1 fault", 64'(fault), 0);

        // R3 basic order
        for (int i = 0; i < 3; i++) push_item(32'h1000 + 4 * i, 32'hA000 + i);
        chk(fill_count == 3, "R8 count after pushes", 64'(fill_count), 3);
        for (int i = 0; i < 3; i++) pop_item(1'b0, "R3 order");
        @(negedge clk);
        chk(fill_count == 0, "R8 count drained", 64'(fill_count), 0);

        // R9 fill to depth, R2 stall and ignored push
        for (int i = 0; i < DEPTH; i++) push_item(32'h2000 + 4 * i, 32'hB000 + i * 7);
        chk(fill_count == CW'(DEPTH), "R9 all accepted", 64'(fill_count), 64'(DEPTH));
        chk(lead_ready == 1'b0, "R2 ready low when full", 64'(lead_ready), 0);
        lead_valid = 1'b1; lead_addr = 32'hDEAD; lead_data = 32'hBEEF;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(fill_count == CW'(DEPTH), "R2 push while full ignored", 64'(fill_count), 64'(DEPTH));
        end
        lead_valid = 1'b0;
        // R3 and R2: drained words match the accepted ones only
        for (int i = 0; i < DEPTH; i++) pop_item(1'b0, "R2 R3 full drain");
        @(negedge clk);
        chk(fill_count == 0, "R2 no extra entry", 64'(fill_count), 0);

        // R4 request on empty queue waits
        trail_req = 1'b1; trail_addr = 32'h3000;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(trail_ack == 1'b0, "R4 no ack while empty", 64'(trail_ack), 0);
        end
        lead_valid = 1'b1; lead_addr = 32'h3000; lead_data = 32'hC0DE;
        @(negedge clk);
        lead_valid = 1'b0;
        do @(negedge clk); while (!trail_ack);
        chk(trail_data == 32'hC0DE, "R4 word after stall", 64'(trail_data), 64'h0C0DE);
        @(negedge clk);
        chk(trail_ack == 1'b0, "R5 ack one cycle", 64'(trail_ack), 0);
        chk(fill_count == 0, "R5 single removal", 64'(fill_count), 0);
        trail_req = 1'b0;

        // R8 simultaneous push and removal, starting full
        for (int i = 0; i < DEPTH; i++) push_item(32'h4000 + 4 * i, 32'hD000 + i);
        fork
            for (int i = 0; i < 10; i++) push_item(32'h5000 + 4 * i, 32'hE000 + 3 * i);
            for (int i = 0; i < DEPTH + 10; i++) pop_item(1'b0, "R8 R3 concurrent");
        join
        @(negedge clk);
        chk(fill_count == 0, "R8 count after concurrent", 64'(fill_count), 0);

        // R8 concurrent from empty
        fork
            for (int i = 0; i < 12; i++) push_item(32'h6000 + 4 * i, 32'hF000 ^ i);
            for (int i = 0; i < 12; i++) pop_item(1'b0, "R8 R4 concurrent empty");
        join
        @(negedge clk);
        chk(fill_count == 0, "R8 count empty run", 64'(fill_count), 0);
        chk(fault == 1'b0, "R6 no fault on matching addresses", 64'(fault), 0);

        // R6 mismatch: still consumed, word still returned
        push_item(32'h7000, 32'h1111);
        push_item(32'h7004, 32'h2222);
        pop_item(1'b1, "R6 word on mismatch");
        chk(fault == 1'b1, "R6 fault raised", 64'(fault), 1);
        chk(fill_count == 1, "R6 entry consumed", 64'(fill_count), 1);
        pop_item(1'b0, "R6 next entry");
        repeat (3) @(negedge clk);
        chk(fault == 1'b1, "R7 fault sticky", 64'(fault), 1);

        do_reset();
        @(negedge clk);
        chk(fault == 1'b0, "R7 reset clears fault", 64'(fault), 0);
        chk(fill_count == 0, "R1 count after reset", 64'(fill_count), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule